// File: doc/BRIEF.md
# Single-Wire Debug Line Sync Responder

This block sits on the target side of a bidirectional open-drain debug line. A host that does not yet know the target's serial rate holds the line low for much longer than any bit cell can last. The block recognises that long low as a synchronisation request. It clears any half-received command in the neighbouring receiver and cancels an acknowledge pulse that is still waiting to go out. It then answers with a reference pulse of known length, timed by its own serial clock. The host measures the low part of that pulse to learn the target's rate.

The serial clock is an enable that fires once every `DIV` core cycles, so all response timing is counted in whole serial ticks. After detection the block waits until the host lets the line go high. It then waits `DELAY_TICKS` ticks, pulls the line low for `LOW_TICKS` ticks, and drives it high for one tick to give a fast rising edge. It then stops driving the line. Any falling edge that arrives while the response is in progress is ignored. Once the response is over, the next long low is treated as a new request.

Top module: `sync_responder`

## Requirements
- R1: The serial tick is one core cycle in every `DIV`, and the tick enable runs freely from reset. Every duration in the response is a whole number of ticks, so the low part of the response lasts exactly `LOW_TICKS*DIV` core cycles and the speedup lasts exactly `DIV` core cycles.
- R2: A request is recognised when the synchronised line has been low on more than `THRESH` consecutive ticks. A low of at most `THRESH*DIV` core cycles is never recognised. A low of at least `(THRESH+2)*DIV` core cycles is always recognised.
- R3: When a request is recognised, `rxSoftReset` goes high for exactly one core cycle. This happens while the host is still holding the line low.
- R4: `ackAbort` goes high for one core cycle, together with `rxSoftReset`, when `ackPending` was high in the detection cycle. In every other cycle it stays low.
- R5: After detection the block does not drive the line while the host keeps it low. It waits for a serial tick on which the line reads high.
- R6: From that tick, the block waits `DELAY_TICKS` serial ticks before it pulls the line low. The gap from the host's release to the first drive is therefore between `DELAY_TICKS*DIV+2` and `DELAY_TICKS*DIV+DIV+3` core cycles, which covers the two-stage input synchroniser.
- R7: The response drives the line low, with `lineOe`=1 and `lineOut`=0, for `LOW_TICKS` ticks.
- R8: The low phase is followed by one tick with `lineOe`=1 and `lineOut`=1, and then `lineOe`=0. `lineOut` is never high while `lineOe` is low.
- R9: While a response is in progress, host lows of any length, including lows longer than the threshold, start no new detection and do not change the response timing.
- R10: Once a response has ended, a new long low is recognised again and produces a complete new response.
- R11: After reset, `lineOe`, `lineOut`, `rxSoftReset` and `ackAbort` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Level read back from the open-drain debug line |
| lineOe | output | 1 | High while the block drives the line |
| lineOut | output | 1 | Level driven when `lineOe` is high (0 for the reference low, 1 for the speedup) |
| ackPending | input | 1 | An acknowledge pulse is waiting to be sent |
| rxSoftReset | output | 1 | One-cycle pulse that clears the command receiver's partial state |
| ackAbort | output | 1 | One-cycle pulse that cancels the pending acknowledge |

## Verification
The assertions check the output shape on every cycle:
- the strobes last one cycle and appear only together as R4 requires;
- `lineOut` is never high without `lineOe`;
- every drive starts low;
- every release follows a speedup;
- nothing is driven in the cycle a request is flagged.

Only the bench scenarios can show the threshold boundary over a sweep of host low lengths, the exact low and speedup lengths, and the delay after release. The same holds for the immunity to host lows during a response and for recognition of a repeated request.

// File: rtl/syncresp_pkg.sv
package syncresp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITHI,
    ST_DELAY,
    ST_DRIVELO,
    ST_SPEEDUP
  } respState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic countLow;   // low-length counter may run
    logic clrPhase;   // restart the phase counter
    logic phaseLong;  // compare against the low-phase length
  } ctrlStrb_t;

  // datapath -> control status
  typedef struct packed {
    logic tick;       // serial clock enable
    logic lineHigh;   // synchronised line level
    logic reqSeen;    // long low crossed the threshold on this tick
    logic phaseDone;  // last tick of the current timed phase
  } dpStat_t;

endpackage

// File: rtl/syncresp_dp.sv
module syncresp_dp
  import syncresp_pkg::*;
#(
  parameter int DIV         = 8,
  parameter int THRESH      = 64,
  parameter int DELAY_TICKS = 16,
  parameter int LOW_TICKS   = 128
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineIn,
  input  ctrlStrb_t strb,
  output dpStat_t   stat
);

  localparam int DW    = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int LW    = $clog2(THRESH + 1) + 1;
  localparam int PMAX  = (DELAY_TICKS > LOW_TICKS) ? DELAY_TICKS : LOW_TICKS;
  localparam int PW    = $clog2(PMAX + 1);

  logic [1:0]    syncFf;
  logic [DW-1:0] divCnt;
  logic [LW-1:0] lowCnt;
  logic [PW-1:0] phaseCnt;
  logic          tick;
  logic          lineHigh;
  logic [PW-1:0] phaseLast;

  // two-stage synchroniser, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncFf <= 2'b11;
    else       syncFf <= {syncFf[0], lineIn};
  end
  assign lineHigh = syncFf[1];

  // serial clock enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end
  assign tick = (divCnt == DW'(DIV - 1));

  // consecutive low ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          lowCnt <= '0;
    else if (!strb.countLow || lineHigh) lowCnt <= '0;
    else if (tick && lowCnt != LW'(THRESH)) lowCnt <= lowCnt + 1'b1;
  end

  // timed phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phaseCnt <= '0;
    else if (strb.clrPhase) phaseCnt <= '0;
    else if (tick)          phaseCnt <= phaseCnt + 1'b1;
  end
  assign phaseLast = strb.phaseLong ? PW'(LOW_TICKS - 1) : PW'(DELAY_TICKS - 1);

  always_comb begin
    stat.tick      = tick;
    stat.lineHigh  = lineHigh;
    stat.reqSeen   = tick && !lineHigh && strb.countLow && (lowCnt == LW'(THRESH));
    stat.phaseDone = tick && (phaseCnt == phaseLast);
  end

endmodule

// File: rtl/syncresp_ctrl.sv
module syncresp_ctrl
  import syncresp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStat_t   stat,
  input  logic      ackPending,
  output ctrlStrb_t strb,
  output logic      lineOe,
  output logic      lineOut,
  output logic      rxSoftReset,
  output logic      ackAbort
);

  respState_t state, stateNx;
  logic       detect;

  always_comb begin
    stateNx       = state;
    strb.countLow = 1'b0;
    strb.clrPhase = 1'b0;
    strb.phaseLong = 1'b0;
    detect        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strb.countLow = 1'b1;
        if (stat.reqSeen) begin
          detect  = 1'b1;
          stateNx = ST_WAITHI;
        end
      end
      ST_WAITHI: begin
        strb.clrPhase = 1'b1;
        if (stat.tick && stat.lineHigh) stateNx = ST_DELAY;
      end
      ST_DELAY: begin
        if (stat.phaseDone) begin
          strb.clrPhase = 1'b1;
          stateNx       = ST_DRIVELO;
        end
      end
      ST_DRIVELO: begin
        strb.phaseLong = 1'b1;
        if (stat.phaseDone) stateNx = ST_SPEEDUP;
      end
      ST_SPEEDUP: begin
        if (stat.tick) stateNx = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      rxSoftReset <= 1'b0;
      ackAbort    <= 1'b0;
    end else begin
      state       <= stateNx;
      rxSoftReset <= detect;
      ackAbort    <= detect && ackPending;
    end
  end

  assign lineOe  = (state == ST_DRIVELO) || (state == ST_SPEEDUP);
  assign lineOut = (state == ST_SPEEDUP);

endmodule

// File: rtl/sync_responder.sv
module sync_responder
  import syncresp_pkg::*;
#(
  parameter int DIV         = 8,
  parameter int THRESH      = 64,
  parameter int DELAY_TICKS = 16,
  parameter int LOW_TICKS   = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOe,
  output logic lineOut,
  input  logic ackPending,
  output logic rxSoftReset,
  output logic ackAbort
);

  ctrlStrb_t strb;
  dpStat_t   stat;

  syncresp_dp #(
    .DIV(DIV), .THRESH(THRESH), .DELAY_TICKS(DELAY_TICKS), .LOW_TICKS(LOW_TICKS)
  ) uDp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strb(strb), .stat(stat)
  );

  syncresp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .stat(stat), .ackPending(ackPending), .strb(strb),
    .lineOe(lineOe), .lineOut(lineOut), .rxSoftReset(rxSoftReset), .ackAbort(ackAbort)
  );

endmodule

// File: rtl/syncresp_chk.sv
module syncresp_chk (
  input logic clk,
  input logic rstN,
  input logic lineOe,
  input logic lineOut,
  input logic ackPending,
  input logic rxSoftReset,
  input logic ackAbort
);

  // R3
  soft_reset_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxSoftReset |=> !rxSoftReset);

  // R4
  ack_abort_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackAbort |-> (rxSoftReset && $past(ackPending)));

  // R4
  ack_abort_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxSoftReset && $past(ackPending)) |-> ackAbort);

  // R8
  out_needs_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineOut |-> lineOe);

  // R7
  drive_starts_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineOe) |-> !lineOut);

  // R8
  release_after_speedup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineOe) |-> $past(lineOut));

  // R5
  no_drive_at_detect_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxSoftReset |-> !lineOe);

endmodule

bind sync_responder syncresp_chk uChk (
  .clk(clk), .rstN(rstN), .lineOe(lineOe), .lineOut(lineOut),
  .ackPending(ackPending), .rxSoftReset(rxSoftReset), .ackAbort(ackAbort)
);

// File: tb/tb_sync_responder.sv
module tb_sync_responder;

  localparam int DIV = 4;
  localparam int THRESH = 5;
  localparam int DELAY_TICKS = 4;
  localparam int LOW_TICKS = 12;
  localparam int GAP_MIN = DELAY_TICKS * DIV + 2;
  localparam int GAP_MAX = DELAY_TICKS * DIV + DIV + 3;
  localparam int SETTLE = (DELAY_TICKS + LOW_TICKS + 2) * DIV + 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostLow = 1'b0;
  logic ackPending = 1'b0;
  logic lineIn, lineOe, lineOut, rxSoftReset, ackAbort;

  int checks = 0, fails = 0;
  int cyc = 0;
  int srTot = 0, abTot = 0, respTot = 0;
  int loRun = 0, hiRun = 0, lastLo = 0, lastHi = 0;
  int riseCyc = 0, srCyc = 0;
  logic prevOe = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  assign lineIn = !(hostLow || (lineOe && !lineOut));

  sync_responder #(
    .DIV(DIV), .THRESH(THRESH), .DELAY_TICKS(DELAY_TICKS), .LOW_TICKS(LOW_TICKS)
  ) dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .lineOe(lineOe), .lineOut(lineOut),
    .ackPending(ackPending), .rxSoftReset(rxSoftReset), .ackAbort(ackAbort)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (rxSoftReset) begin srTot <= srTot + 1; srCyc <= cyc; end
      if (ackAbort) abTot <= abTot + 1;
      if (lineOe && !prevOe) riseCyc <= cyc;
      if (!lineOe && prevOe) respTot <= respTot + 1;
      if (lineOe && !lineOut) loRun <= loRun + 1;
      else if (loRun != 0) begin lastLo <= loRun; loRun <= 0; end
      if (lineOe && lineOut) hiRun <= hiRun + 1;
      else if (hiRun != 0) begin lastHi <= hiRun; hiRun <= 0; end
      prevOe <= lineOe;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int relCyc, sr0, ab0, rs0;
    waitCyc(3);
    // R11 reset state
    check("R11 lineOe", int'(lineOe), 0);
    check("R11 lineOut", int'(lineOut), 0);
    check("R11 rxSoftReset", int'(rxSoftReset), 0);
    check("R11 ackAbort", int'(ackAbort), 0);
    rstN = 1'b1;
    waitCyc(5);

    // sweep of host low lengths: R1 R2 R3 R4 R5 R6 R7 R8 R10
    for (int len = 1; len <= (THRESH + 4) * DIV; len++) begin
      sr0 = srTot; ab0 = abTot; rs0 = respTot;
      ackPending = len[0];
      hostLow = 1'b1;
      waitCyc(len);
      hostLow = 1'b0;
      relCyc = cyc;
      waitCyc(SETTLE);
      ackPending = 1'b0;
      if (len <= THRESH * DIV) begin
        check("R2 short low ignored", srTot - sr0, 0);
        check("R2 short low no drive", respTot - rs0, 0);
        check("R4 no abort without detect", abTot - ab0, 0);
      end else if (len >= (THRESH + 2) * DIV) begin
        check("R2 long low detected", srTot - sr0, 1);
        check("R3 pulse while host low", int'(srCyc < relCyc), 1);
        check("R4 abort follows ackPending", abTot - ab0, len % 2);
        check("R10 response completed", respTot - rs0, 1);
        check("R5 no drive before release", int'(riseCyc > relCyc), 1);
        checkRange("R6 delay after release", riseCyc - relCyc, GAP_MIN, GAP_MAX);
        check("R7 low drive length R1", lastLo, LOW_TICKS * DIV);
        check("R8 speedup length", lastHi, DIV);
        check("R8 released", int'(lineOe), 0);
      end
    end

    // R9 host lows during delay and during the driven low
    sr0 = srTot; rs0 = respTot;
    hostLow = 1'b1;
    waitCyc((THRESH + 3) * DIV);
    hostLow = 1'b0;
    relCyc = cyc;
    waitCyc(8);
    hostLow = 1'b1;
    waitCyc(DIV);
    hostLow = 1'b0;
    waitCyc(30 - 8 - DIV);
    hostLow = 1'b1;
    waitCyc((THRESH + 2) * DIV);
    hostLow = 1'b0;
    waitCyc(SETTLE);
    check("R9 single detection", srTot - sr0, 1);
    check("R9 single response", respTot - rs0, 1);
    checkRange("R9 delay unchanged", riseCyc - relCyc, GAP_MIN, GAP_MAX);
    check("R9 low length unchanged", lastLo, LOW_TICKS * DIV);
    check("R9 speedup unchanged", lastHi, DIV);

    // R10 back-to-back request after the response
    sr0 = srTot; rs0 = respTot;
    hostLow = 1'b1;
    waitCyc((THRESH + 3) * DIV);
    hostLow = 1'b0;
    waitCyc(SETTLE);
    check("R10 new request detected", srTot - sr0, 1);
    check("R10 new response", respTot - rs0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule